// File: doc/BRIEF.md
# Nondestructive Shadow Scan Chain

This block holds a bank of functional state bits next to an equal number of shadow bits. The functional bits run on their own clock and take their normal next-state value each cycle. The shadow bits form a serial chain with a separate scan clock, a serial input and a serial output. A snapshot operation copies the whole functional bank into the shadow chain in one scan-clock edge. The snapshot can then be shifted out bit by bit while the functional logic keeps running untouched. In the other direction, a pattern shifted into the shadow chain can be written into the functional bank in a single functional-clock cycle.

On each scan-clock edge the shadow chain applies one of three operations. These are decoded from the capture and shift controls, with capture taking priority: HOLD keeps the chain as it is, SHIFT moves it one place toward the output, and CAPTURE copies the snapshot. On each functional-clock edge the bank applies one of two operations: RUN takes the data input, and LOAD takes the shadow contents for that cycle only. Controls are sampled synchronously in their own clock domain. The user keeps capture stable around scan edges and load stable around functional edges. WIDTH is at least 2.

Top module: `nd_shadow_scan`

## Requirements
- R1: While func_rst_n is low, func_q is all zeros. While scan_rst_n is low, every shadow bit is zero, so scan_out is 0.
- R2: On a functional clock edge with load_en low (RUN), func_q takes the value of func_d.
- R3: On a functional clock edge with load_en high (LOAD), func_q takes the shadow chain contents bit for bit. On the following edge with load_en low, it returns to following func_d.
- R4: On a scan clock edge with capture_en high (CAPTURE), each shadow bit i stores func_q[i] as it stands at that edge.
- R5: When capture_en and shift_en are both high on a scan edge, the capture is performed and no shift takes place.
- R6: On a scan edge with shift_en high and capture_en low (SHIFT), scan_in enters shadow bit 0 and bit i moves to bit i+1. scan_out always shows shadow bit WIDTH-1, so a snapshot appears most significant bit first over one capture edge and WIDTH-1 shift edges.
- R7: On a scan edge with capture_en and shift_en both low (HOLD), the shadow chain keeps its value.
- R8: Scan activity of any kind (capture, shift or hold) never changes func_q. func_q keeps following R2 and R3 while the chain is shifting.
- R9: Several captures, each followed by a full readout, may be performed in one run without stopping the functional clock. Each readout shows the functional state at its own capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_clk | input | 1 | Functional clock |
| func_rst_n | input | 1 | Asynchronous active-low reset of the functional bank |
| func_d | input | WIDTH | Normal next-state value of the functional bank |
| load_en | input | 1 | Write shadow contents into the functional bank on the next functional edge |
| func_q | output | WIDTH | Functional bank state |
| scan_clk | input | 1 | Scan clock for the shadow chain |
| scan_rst_n | input | 1 | Asynchronous active-low reset of the shadow chain |
| capture_en | input | 1 | Snapshot the functional bank into the shadow chain |
| shift_en | input | 1 | Shift the shadow chain by one place |
| scan_in | input | 1 | Serial input into shadow bit 0 |
| scan_out | output | 1 | Serial output, shadow bit WIDTH-1 |

## Verification
The bench builds the block with WIDTH set to 12. A functional counter of that width changes value on every cycle, so two captures taken at different times give distinct snapshots, and a readout of eleven shifts exercises every link of the chain. The clock periods are 10 and 16 time units, with edges that never coincide. This lets captures fall at many different phases of the running counter and lets loads land between scan edges without ambiguity. A shifted-in pattern of mixed ones and zeros across all twelve bits makes a dropped or misrouted link visible after a load.

// File: rtl/nds_pkg.sv
package nds_pkg;

    typedef enum logic [1:0] {
        SOP_HOLD    = 2'd0,
        SOP_SHIFT   = 2'd1,
        SOP_CAPTURE = 2'd2
    } scan_op_e;

    typedef enum logic {
        FOP_RUN  = 1'b0,
        FOP_LOAD = 1'b1
    } func_op_e;

endpackage

// File: rtl/scan_op_decode.sv
module scan_op_decode
    import nds_pkg::*;
(
    input  logic     capture_en,
    input  logic     shift_en,
    output scan_op_e op
);

    always_comb begin
        unique case ({capture_en, shift_en})
            2'b10, 2'b11: op = SOP_CAPTURE;
            2'b01:        op = SOP_SHIFT;
            default:      op = SOP_HOLD;
        endcase
    end

endmodule

// File: rtl/func_bank.sv
module func_bank
    import nds_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] shadow_q,
    output logic [WIDTH-1:0] q
);

    func_op_e         fop;
    logic [WIDTH-1:0] q_next;

    always_comb begin
        fop = load_en ? FOP_LOAD : FOP_RUN;
    end

    always_comb begin
        unique case (fop)
            FOP_LOAD: q_next = shadow_q;
            default:  q_next = d;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

    // R2: a run cycle takes the normal data input
    a_r2_run_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> q == $past(d));

    // R3: a load cycle takes the shadow contents
    a_r3_load_takes_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> q == $past(shadow_q));

endmodule

// File: rtl/shadow_chain.sv
module shadow_chain
    import nds_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  scan_op_e         op,
    input  logic             scan_in,
    input  logic [WIDTH-1:0] func_q,
    output logic [WIDTH-1:0] sh_q
);

    logic [WIDTH-1:0] sh_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic link_src;
        logic cell_next;

        if (i == 0) begin : g_head
            assign link_src = scan_in;
        end else begin : g_link
            assign link_src = sh_q[i-1];
        end

        always_comb begin
            unique case (op)
                SOP_CAPTURE: cell_next = func_q[i];
                SOP_SHIFT:   cell_next = link_src;
                default:     cell_next = sh_q[i];
            endcase
        end

        assign sh_d[i] = cell_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    // R4: capture copies the functional bank
    a_r4_capture_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        op == SOP_CAPTURE |=> sh_q == $past(func_q));

    // R6: shift moves one place toward the output
    a_r6_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        op == SOP_SHIFT |=> sh_q == {$past(sh_q[WIDTH-2:0]), $past(scan_in)});

    // R7: hold keeps the chain
    a_r7_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        op == SOP_HOLD |=> $stable(sh_q));

endmodule

// File: rtl/nd_shadow_scan.sv
module nd_shadow_scan
    import nds_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             func_clk,
    input  logic             func_rst_n,
    input  logic [WIDTH-1:0] func_d,
    input  logic             load_en,
    output logic [WIDTH-1:0] func_q,
    input  logic             scan_clk,
    input  logic             scan_rst_n,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             scan_in,
    output logic             scan_out
);

    localparam int MSB = WIDTH - 1;

    scan_op_e         scan_op;
    logic [WIDTH-1:0] shadow;

    scan_op_decode u_decode (
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .op         (scan_op)
    );

    shadow_chain #(.WIDTH(WIDTH)) u_chain (
        .clk     (scan_clk),
        .rst_n   (scan_rst_n),
        .op      (scan_op),
        .scan_in (scan_in),
        .func_q  (func_q),
        .sh_q    (shadow)
    );

    func_bank #(.WIDTH(WIDTH)) u_bank (
        .clk      (func_clk),
        .rst_n    (func_rst_n),
        .load_en  (load_en),
        .d        (func_d),
        .shadow_q (shadow),
        .q        (func_q)
    );

    assign scan_out = shadow[MSB];

    // R5: capture wins over a simultaneous shift
    a_r5_capture_over_shift: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
        (capture_en && shift_en) |=> shadow == $past(func_q));

    // R6: serial output presents the top shadow bit after a shift
    a_r6_out_tracks_chain: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
        (shift_en && !capture_en) |=> scan_out == $past(shadow[MSB-1]));

endmodule

// File: tb/nd_shadow_scan_test.sv
module nd_shadow_scan_test;

    localparam int N            = 12;
    localparam int FCLK_PERIOD  = 10;
    localparam int SCLK_PERIOD  = 16;
    localparam int WATCHDOG_T   = FCLK_PERIOD * 20000;

    logic         func_clk = 1'b0;
    logic         scan_clk = 1'b0;
    logic         func_rst_n = 1'b0;
    logic         scan_rst_n = 1'b0;
    logic [N-1:0] func_d = '0;
    logic         load_en = 1'b0;
    logic [N-1:0] func_q;
    logic         capture_en = 1'b0;
    logic         shift_en = 1'b0;
    logic         scan_in = 1'b0;
    logic         scan_out;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit shifting = 1'b0;
    bit done = 1'b0;

    logic [N-1:0] model_sh = '0;
    logic         exp_bits[$];
    string        exp_tags[$];

    nd_shadow_scan #(.WIDTH(N)) uut (
        .func_clk   (func_clk),
        .func_rst_n (func_rst_n),
        .func_d     (func_d),
        .load_en    (load_en),
        .func_q     (func_q),
        .scan_clk   (scan_clk),
        .scan_rst_n (scan_rst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .scan_in    (scan_in),
        .scan_out   (scan_out)
    );

    always #(FCLK_PERIOD/2) func_clk = ~func_clk;
    always #(SCLK_PERIOD/2) scan_clk = ~scan_clk;

    task automatic check(input bit ok, input string tag,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // running counter as functional data
    initial begin
        forever begin
            @(negedge func_clk);
            func_d <= func_d + 1'b1;
        end
    end

    // functional monitor: R2, R3, R8
    initial begin
        logic [N-1:0] expv;
        string        tag;
        wait (mon_on);
        forever begin
            @(posedge func_clk);
            expv = load_en ? model_sh : func_d;
            tag  = load_en ? "R3" : (shifting ? "R8" : "R2");
            #2;
            check(func_q == expv, tag, func_q, expv);
        end
    end

    // scan scoreboard monitor
    initial begin
        logic  eb;
        string et;
        wait (mon_on);
        forever begin
            @(posedge scan_clk);
            #3;
            while (exp_bits.size() > 0) begin
                eb = exp_bits.pop_front();
                et = exp_tags.pop_front();
                check(scan_out == eb, et, {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, eb});
            end
        end
    end

    // scan driver: applies one operation and pushes the expected output bit
    task automatic scan_step(input logic cap, input logic shf, input logic sin, input string tag);
        @(negedge scan_clk);
        capture_en = cap;
        shift_en   = shf;
        scan_in    = sin;
        shifting   = shf;
        @(posedge scan_clk);
        if (cap)      model_sh = func_q;
        else if (shf) model_sh = {model_sh[N-2:0], sin};
        exp_bits.push_back(model_sh[N-1]);
        exp_tags.push_back(tag);
    endtask

    task automatic readout(input string tag);
        for (int k = 0; k < N-1; k++) begin
            scan_step(1'b0, 1'b1, logic'(k % 3 == 0), tag);
        end
    endtask

    task automatic scan_idle(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            scan_step(1'b0, 1'b0, 1'b0, "R7");
        end
        shifting = 1'b0;
    endtask

    task automatic print_summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(WATCHDOG_T);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            print_summary();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pat;
        logic [N-1:0] snap1;

        // R1: reset state
        repeat (3) @(negedge func_clk);
        check(func_q == '0, "R1", func_q, '0);
        check(scan_out == 1'b0, "R1", {{(N-1){1'b0}}, scan_out}, '0);
        @(negedge func_clk);
        func_rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge scan_clk);
        check(scan_out == 1'b0, "R1", {{(N-1){1'b0}}, scan_out}, '0);
        scan_rst_n = 1'b1;

        // R7: chain holds while functional logic runs
        scan_idle(4);

        // R4 and R6: first snapshot and readout, R8 checked meanwhile
        scan_step(1'b1, 1'b0, 1'b0, "R4");
        snap1 = model_sh;
        readout("R6");
        scan_idle(3);

        // R9: second snapshot at a later time
        scan_step(1'b1, 1'b0, 1'b0, "R9");
        check(model_sh != snap1, "R9", model_sh, snap1);
        readout("R9");
        scan_idle(2);

        // R5: capture and shift together
        scan_step(1'b1, 1'b1, 1'b1, "R5");
        readout("R5");
        scan_idle(2);

        // R6 then R3: shift in a pattern and load it
        for (int i = 0; i < N; i++) pat[i] = (i % 3 != 1);
        for (int k = 0; k < N; k++) begin
            scan_step(1'b0, 1'b1, pat[N-1-k], "R6");
        end
        scan_idle(1);
        check(model_sh == pat, "R6", model_sh, pat);
        @(negedge func_clk);
        load_en = 1'b1;
        @(negedge func_clk);
        load_en = 1'b0;
        check(func_q == pat, "R3", func_q, pat);
        @(negedge func_clk);
        check(func_q != pat, "R3", func_q, pat);

        // R7: chain unchanged by the load
        scan_idle(2);
        check(model_sh == pat, "R7", model_sh, pat);
        readout("R6");
        scan_idle(2);

        repeat (4) @(negedge func_clk);
        done = 1'b1;
        print_summary();
        $finish;
    end

endmodule